// File: doc/BRIEF.md
# Fractional-Rate Realtime Counter

This block keeps a free-running 64-bit time count that advances at a fixed nominal rate (6.144 MHz) regardless of the frequency of the clock it runs on. It does this with a fractional increment. Every clock cycle, a programmable numerator is added to a small accumulator. Whenever the accumulator reaches the programmable denominator, the denominator is taken away and the count steps by one. The average count rate is therefore input_rate × numerator / denominator.

Software chooses the ratio that suits the input clock. Examples:

- 4/25 for 38.4 MHz
- 8/25 for 19.2 MHz
- 64/125 for 12 MHz
- 192/625 for 20 MHz
- 256/1125 for 27 MHz
- 384/1625 for 26 MHz
- 768/1625 for 13 MHz
- 75/244 when the slow reference is derived from the system clock divided by 610 at 20 MHz. Without this correction the count would run about 570 ppm fast.

A simple 32-bit register port holds the two ratio words and reads the count. The count is also driven as a plain output for timer logic nearby. A read of the low count word captures the upper word, so that two reads always form a consistent 64-bit value.

Top module: `frac_rate_counter`

## Requirements
- R1: After a synchronous reset the count equals RESET_COUNT (default zero), the accumulator is zero, the numerator word reads 0x00000004 and the denominator word reads 0x00000019 (ratio 4/25).
- R2: The numerator word is at byte address 0x10 and the denominator word at 0x14. Each holds and reads back all 32 bits written, but only bits [11:0] form the ratio. The count low word is at 0x00 and the captured upper word at 0x04. Any other address reads zero and no register changes without a write to its own address.
- R3: In each cycle with a non-zero denominator and no ratio write, the numerator is added to the accumulator. If the sum is at least the denominator, the denominator is subtracted and the count rises by exactly one. Starting from a cleared accumulator, N such cycles raise the count by floor(N × num / den).
- R4: A write to either ratio word clears the accumulator, and the count does not advance in that cycle. The new ratio applies from the next cycle.
- R5: While bits [11:0] of the denominator word are zero, the count and the accumulator hold, whatever the numerator is.
- R6: A read (bus_rd high) returns data on bus_rdata in the following cycle. A read of 0x00 returns count[31:0] and captures count[63:32]; a read of 0x04 returns that captured word, even if the count has since carried into its upper half.
- R7: The count carries from bit 31 into bit 32 like a plain 64-bit counter, and rt_count always shows the live count.
- R8: With num ≤ den and den non-zero, the accumulator stays below the denominator, so at most one step occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock of any supported frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rt_count | output | 64 | Live realtime count |

## Verification
The bench builds the counter with RESET_COUNT = 0x0000_0000_FFFF_FFF0 and all other parameters at their defaults (12-bit ratio fields, reset ratio 4/25). With that reset value, the carry from the low word into the upper word happens within a few dozen cycles of a 1/1 ratio. This makes it possible to show that the captured upper word stays at its pre-carry value while the live count has moved on. The long-ratio runs then start above 2^32, so every rate check also exercises a non-zero upper word. The denominator-zero hold is used to freeze the count around each measured window, which lets the expected step count be derived exactly from the ratio and the cycle count.

// File: rtl/frac_rate_pkg.sv
// Package: shared register addresses and bus width for the fractional-rate
// realtime counter. Assumes an 8-bit byte address and a 32-bit data port.
package frac_rate_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_NUM    = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_DEN    = 8'h14;
endpackage

// File: rtl/frac_ratio_regs.sv
// Module: holds the numerator and denominator words. All 32 bits are kept for
// read-back, and the low RATIO_W bits form the ratio. Flags any ratio write so
// that the accumulator can be cleared. Assumes single-cycle write strobes.
module frac_ratio_regs
    import frac_rate_pkg::*;
#(
    parameter int RATIO_W = 12,
    parameter int NUM_RST = 4,
    parameter int DEN_RST = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  num_word,
    output logic [BUS_W-1:0]  den_word,
    output logic [RATIO_W-1:0] num,
    output logic [RATIO_W-1:0] den,
    output logic              ratio_wr
);
    logic hit_num, hit_den;

    // Decode which ratio word a write targets.
    always_comb begin
        hit_num  = wr && (addr == ADR_NUM);
        hit_den  = wr && (addr == ADR_DEN);
        ratio_wr = hit_num || hit_den;
    end

    // Store the numerator word.
    always_ff @(posedge clk) begin
        if (!rst_n)       num_word <= BUS_W'(NUM_RST);
        else if (hit_num) num_word <= wdata;
    end

    // Store the denominator word.
    always_ff @(posedge clk) begin
        if (!rst_n)       den_word <= BUS_W'(DEN_RST);
        else if (hit_den) den_word <= wdata;
    end

    assign num = num_word[RATIO_W-1:0];
    assign den = den_word[RATIO_W-1:0];

    AST_NUM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADR_NUM) |=> $stable(num_word)); // R2
    AST_DEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADR_DEN) |=> $stable(den_word)); // R2
endmodule

// File: rtl/frac_step_gen.sv
// Module: fractional accumulator. Adds the numerator every cycle and raises
// step when the sum reaches the denominator, subtracting it. A zero
// denominator holds the accumulator, and clr empties it. Assumes num <= den
// for the accumulator to stay bounded.
module frac_step_gen #(
    parameter int RATIO_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] num,
    input  logic [RATIO_W-1:0] den,
    input  logic               clr,
    output logic               step
);
    localparam int ACC_W = RATIO_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] den_x;
    logic             den_zero;
    logic             reach;

    // Form the next sum and compare it with the denominator.
    always_comb begin
        den_x    = ACC_W'(den);
        den_zero = (den == '0);
        sum      = acc_q + ACC_W'(num);
        reach    = !den_zero && (sum >= den_x);
        step     = reach && !clr;
    end

    // Update the accumulator: clear, hold, wrap or add.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (clr)      acc_q <= '0;
        else if (den_zero) acc_q <= acc_q;
        else if (reach)    acc_q <= sum - den_x;
        else               acc_q <= sum;
    end

    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (den != '0 && num <= den) |-> (acc_q < ACC_W'(den))); // R8
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0)); // R4
endmodule

// File: rtl/frac_count_core.sv
// Module: the free-running count. Steps by one when requested and captures
// the upper half when the low word is read. Assumes CNT_W lies in 33..64.
module frac_count_core #(
    parameter int          CNT_W       = 64,
    parameter logic [63:0] RESET_COUNT = 64'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             snap_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-33:0] snap_hi
);
    localparam int HI_W = CNT_W - 32;

    // Advance the count on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= CNT_W'(RESET_COUNT);
        else if (step) count <= count + CNT_W'(1);
    end

    // Capture the upper half when the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_hi <= '0;
        else if (snap_en) snap_hi <= count[CNT_W-1:32];
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R3
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(snap_hi)); // R6
    AST_HI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count[32]) |-> ($past(count[31:0]) == 32'hFFFF_FFFF)); // R7
    initial begin
        assert (HI_W >= 1);
    end
endmodule

// File: rtl/frac_rate_counter.sv
// Module: top of the fractional-rate realtime counter. Joins the ratio
// registers, the accumulator and the count, and provides a registered read
// port. Assumes single-cycle bus strobes and num <= den.
module frac_rate_counter
    import frac_rate_pkg::*;
#(
    parameter int          RATIO_W     = 12,
    parameter int          NUM_RST     = 4,
    parameter int          DEN_RST     = 25,
    parameter int          CNT_W       = 64,
    parameter logic [63:0] RESET_COUNT = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  rt_count
);
    logic [BUS_W-1:0]   num_word, den_word;
    logic [RATIO_W-1:0] num, den;
    logic               ratio_wr;
    logic               step;
    logic               snap_en;
    logic [CNT_W-33:0]  snap_hi;

    frac_ratio_regs #(
        .RATIO_W (RATIO_W),
        .NUM_RST (NUM_RST),
        .DEN_RST (DEN_RST)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .num_word (num_word),
        .den_word (den_word),
        .num      (num),
        .den      (den),
        .ratio_wr (ratio_wr)
    );

    frac_step_gen #(
        .RATIO_W (RATIO_W)
    ) step_i (
        .clk   (clk),
        .rst_n (rst_n),
        .num   (num),
        .den   (den),
        .clr   (ratio_wr),
        .step  (step)
    );

    assign snap_en = bus_rd && (bus_addr == ADR_CNT_LO);

    frac_count_core #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .snap_en (snap_en),
        .count   (rt_count),
        .snap_hi (snap_hi)
    );

    // Register the read data selected by the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                ADR_CNT_LO: bus_rdata <= rt_count[31:0];
                ADR_CNT_HI: bus_rdata <= BUS_W'(snap_hi);
                ADR_NUM:    bus_rdata <= num_word;
                ADR_DEN:    bus_rdata <= den_word;
                default:    bus_rdata <= '0;
            endcase
        end
    end

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (den_word[RATIO_W-1:0] == '0) |=> (rt_count == $past(rt_count))); // R5
    AST_WRITE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADR_NUM || bus_addr == ADR_DEN))
        |=> (rt_count == $past(rt_count))); // R4
    AST_RD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_CNT_LO) |=> (bus_rdata == $past(rt_count[31:0]))); // R6
    AST_RD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_CNT_HI) |=> (bus_rdata == BUS_W'($past(snap_hi)))); // R6
endmodule

// File: tb/frac_rate_counter_tb_top.sv
// Bench: directed scenarios for the fractional-rate realtime counter.
module frac_rate_counter_tb_top;
    localparam logic [63:0] RST_CNT = 64'h0000_0000_FFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] rt_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frac_rate_counter #(.RESET_COUNT(RST_CNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rt_count(rt_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_count(output logic [63:0] c);
        logic [31:0] lo, hi;
        rd_reg(8'h00, lo);
        rd_reg(8'h04, hi);
        c = {hi, lo};
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [63:0] c;
        rd_count(c);
        chk("R1 count", c, RST_CNT);
        rd_reg(8'h10, d);
        chk("R1 num", 64'(d), 64'h4);
        rd_reg(8'h14, d);
        chk("R1 den", 64'(d), 64'h19);
        rd_reg(8'h08, d);
        chk("R2 unmapped", 64'(d), 64'h0);
    endtask

    // Low read captures upper word; later carry does not disturb it.
    task automatic t_coherent();
        logic [63:0] c0, c1;
        logic [31:0] lo, hi;
        wr_reg(8'h14, 32'h0);
        rd_count(c0);
        wr_reg(8'h10, 32'h1);
        wr_reg(8'h14, 32'h1);
        rd_reg(8'h00, lo);
        repeat (30) @(negedge clk);
        rd_reg(8'h04, hi);
        wr_reg(8'h14, 32'h0);
        chk("R6 low word", 64'(lo), 64'(c0[31:0]));
        chk("R6 captured upper", 64'(hi), 64'(c0[63:32]));
        rd_count(c1);
        chk("R7 carry into upper", c1, c0 + 64'd32);
        chk("R7 live output", rt_count, c0 + 64'd32);
    endtask

    task automatic t_ratio(input string req, input logic [31:0] nw, input logic [31:0] dw,
                           input int n_cyc);
        logic [63:0] c0, c1, exp;
        logic [31:0] d;
        wr_reg(8'h14, 32'h0);
        rd_count(c0);
        wr_reg(8'h10, nw);
        wr_reg(8'h14, dw);
        repeat (n_cyc) @(negedge clk);
        wr_reg(8'h14, 32'h0);
        rd_count(c1);
        exp = c0 + (64'(n_cyc) * 64'(nw[11:0])) / 64'(dw[11:0]);
        chk(req, c1, exp);
        chk("R7 output matches", rt_count, c1);
        rd_reg(8'h10, d);
        chk("R2 num readback", 64'(d), 64'(nw));
    endtask

    // Rewriting the numerator mid-run must empty the accumulator.
    task automatic t_clear();
        logic [63:0] c0, c1;
        wr_reg(8'h14, 32'h0);
        rd_count(c0);
        wr_reg(8'h10, 32'd4);
        wr_reg(8'h14, 32'd25);
        repeat (5) @(negedge clk);
        wr_reg(8'h10, 32'd4);
        repeat (6) @(negedge clk);
        wr_reg(8'h14, 32'h0);
        rd_count(c1);
        chk("R4 write clears accumulator", c1, c0);
    endtask

    task automatic t_hold();
        logic [63:0] c0, c1;
        logic [31:0] d;
        wr_reg(8'h14, 32'h00FF_F000);
        rd_count(c0);
        repeat (300) @(negedge clk);
        wr_reg(8'h10, 32'd100);
        repeat (50) @(negedge clk);
        rd_count(c1);
        chk("R5 zero denominator holds", c1, c0);
        rd_reg(8'h14, d);
        chk("R2 den upper bits kept", 64'(d), 64'h00FF_F000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_coherent();
        t_ratio("R3 4/25",      32'd4,   32'd25,   1000);
        t_ratio("R3 64/125",    32'd64,  32'd125,  1000);
        t_ratio("R3 768/1625",  32'd768, 32'd1625, 3300);
        t_ratio("R3 8/25",      32'd8,   32'd25,   777);
        t_ratio("R3 192/625",   32'd192, 32'd625,  1250);
        t_ratio("R3 384/1625",  32'd384, 32'd1625, 2000);
        t_ratio("R3 256/1125",  32'd256, 32'd1125, 2251);
        t_ratio("R3 75/244",    32'd75,  32'd244,  977);
        t_ratio("R3 short 4/25 six cycles", 32'd4, 32'd25, 6);
        t_ratio("R2 low field only", 32'hABCD_E040, 32'h1234_507D, 1000);
        t_clear();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule